// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block takes one 6-bit operand specifier for a 16-bit, byte-addressed, little-endian machine with eight general registers. It turns the specifier into a register operand or a memory effective address. The upper three specifier bits choose an addressing mode and the lower three choose a register. R6 is the stack pointer and R7 is the program counter. The block reads the register file through a single read port and writes back any pointer update through a single write port. It fetches a 16-bit extension word at the program counter, or reads a pointer word, through a request/acknowledge memory port.

A controller raises `start` for one cycle with the specifier and the byte/word flag. The block then runs on its own. It finishes with a one-cycle `done`, which means `ea` and `is_reg` are valid, or with a one-cycle `align_err`. The block does not fetch the final operand and does not decode anything beyond the specifier. With R7, the ordinary modes give immediate, absolute and PC-relative addressing without any special case.

Top module: `opnd_ea_seq`

## Requirements
- R1: Mode 0 (specifier bits 5:3 = 0) finishes with `done`, `is_reg`=1 and `ea` equal to the register number (bits 2:0), with no memory request and no register write.
- R2: Mode 1 gives `ea` = register value. Mode 2 gives `ea` = register value and then writes register + stride. Mode 4 writes register − stride and gives that value as `ea`. The stride is 1 when `byte_op`=1 and 2 when `byte_op`=0.
- R3: Mode 3 reads a pointer word at the register value and then writes register + 2. Mode 5 writes register − 2 and reads a pointer word at that address. In both modes `ea` is the pointer word read, and the stride is 2 even for byte operations.
- R4: When the register is R6 or R7, the increment and decrement stride is 2 even when `byte_op`=1.
- R5: Modes 6 and 7 read an extension word at the current R7 value and write R7 + 2 back to R7. Mode 6 gives `ea` = register + extension. Mode 7 reads a pointer word at that sum and gives it as `ea`. With R7 as the register, the sum uses the advanced R7 value.
- R6: With R7, mode 2 gives `ea` equal to the extension word's own address (immediate). Mode 3 gives `ea` equal to the extension word's content (absolute). Both advance R7 by 2.
- R7: `align_err` is raised, and `done` is not, in these cases: a word access address is odd; a pointer read address is odd; an extension fetch address is odd; or a word-operation pointer value or mode-6 sum is odd. A mode 1/2/4 word error and a mode 3/5 odd pointer address are detected before any register write. An odd pointer value found after a writeback leaves that single writeback in place.
- R8: `mem_req` stays high with `mem_addr` stable until `mem_ack`, `mem_addr` is always even, and at most two reads are acknowledged per specifier.
- R9: At most one register write happens per specifier, and it happens before `done` or `align_err`.
- R10: After reset, `done`, `align_err`, `mem_req` and `rf_we` are low. `done` and `align_err` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin resolving `spec`; ignored while busy |
| spec | input | 6 | Mode in bits 5:3, register in bits 2:0 |
| byte_op | input | 1 | 1 = byte operation, 0 = word operation |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 16 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 16 | Register file write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |
| ea | output | 16 | Effective address, or register number when `is_reg` |
| is_reg | output | 1 | Result is a register operand |
| done | output | 1 | One-cycle pulse: result valid |
| align_err | output | 1 | One-cycle pulse: sequence aborted on odd address |

## Verification
The bench covers the following corner cases:

- **Stride choice.** It runs byte post-increment and pre-decrement on ordinary registers, on R6 and on R7. A design that ignored the stack-pointer/program-counter rule would leave R6 odd after a byte push.
- **Deferred modes on bytes.** It runs deferred modes with byte operations. A stride taken from `byte_op` alone would move the register by 1 instead of 2.
- **PC-relative base.** It checks PC-relative modes where the base must be the advanced program counter. A design using the stale value would give an address two bytes short.
- **Error ordering.** Odd word addresses must leave the register untouched. An odd pointer value must keep the single writeback already made. An odd program counter must abort before any request. A design with the wrong ordering would corrupt or skip register updates.

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [5:0]   spec,
  input  logic         byte_op,
  output logic [2:0]   rf_raddr,
  input  logic [W-1:0] rf_rdata,
  output logic         rf_we,
  output logic [2:0]   rf_waddr,
  output logic [W-1:0] rf_wdata,
  output logic         mem_req,
  output logic [W-1:0] mem_addr,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata,
  output logic [W-1:0] ea,
  output logic         is_reg,
  output logic         done,
  output logic         align_err
);
  localparam logic [2:0] PC_IDX = 3'd7;
  localparam logic [2:0] SP_IDX = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_CALC, S_EXT, S_PTR, S_DONE, S_ERR} st_t;
  st_t st;

  logic [2:0]   md, rg;
  logic         bop;
  logic [W-1:0] rv, paddr, ea_q;
  logic         isr_q;

  wire two    = !bop || md == 3'd3 || md == 3'd5 || rg == SP_IDX || rg == PC_IDX;
  wire [W-1:0] stride = two ? W'(2) : W'(1);
  wire [W-1:0] inc    = rv + stride;
  wire [W-1:0] dec    = rv - stride;
  wire [W-1:0] caddr  = (md == 3'd4 || md == 3'd5) ? dec : rv;
  wire plain  = md == 3'd1 || md == 3'd2 || md == 3'd4;
  wire defer  = md == 3'd3 || md == 3'd5;
  wire calc_bad = (plain && !bop && caddr[0]) || (defer && caddr[0]);
  wire [W-1:0] pc_next = rf_rdata + W'(2);
  wire [W-1:0] ext_sum = ((rg == PC_IDX) ? pc_next : rv) + mem_rdata;
  wire pc_odd = rf_rdata[0];

  assign rf_raddr = (st == S_IDLE) ? spec[2:0] : PC_IDX;
  assign mem_req  = (st == S_EXT && !pc_odd) || st == S_PTR;
  assign mem_addr = (st == S_EXT) ? rf_rdata : paddr;
  assign rf_we    = (st == S_CALC && (md == 3'd2 || defer || md == 3'd4) && !calc_bad)
                 || (st == S_EXT && !pc_odd && mem_ack);
  assign rf_waddr = (st == S_EXT) ? PC_IDX : rg;
  assign rf_wdata = (st == S_EXT) ? pc_next : ((md >= 3'd4) ? dec : inc);
  assign ea        = ea_q;
  assign is_reg    = isr_q;
  assign done      = st == S_DONE;
  assign align_err = st == S_ERR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      md    <= '0;
      rg    <= '0;
      bop   <= 1'b0;
      rv    <= '0;
      paddr <= '0;
      ea_q  <= '0;
      isr_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          md    <= spec[5:3];
          rg    <= spec[2:0];
          bop   <= byte_op;
          rv    <= rf_rdata;
          isr_q <= 1'b0;
          st    <= S_CALC;
        end
        S_CALC: begin
          if (md == 3'd0) begin
            ea_q  <= {{(W-3){1'b0}}, rg};
            isr_q <= 1'b1;
            st    <= S_DONE;
          end else if (md == 3'd6 || md == 3'd7) begin
            st <= S_EXT;
          end else if (calc_bad) begin
            st <= S_ERR;
          end else if (defer) begin
            paddr <= caddr;
            st    <= S_PTR;
          end else begin
            ea_q <= caddr;
            st   <= S_DONE;
          end
        end
        S_EXT: begin
          if (pc_odd) st <= S_ERR;
          else if (mem_ack) begin
            if (md == 3'd6) begin
              ea_q <= ext_sum;
              st   <= (!bop && ext_sum[0]) ? S_ERR : S_DONE;
            end else begin
              paddr <= ext_sum;
              st    <= ext_sum[0] ? S_ERR : S_PTR;
            end
          end
        end
        S_PTR: if (mem_ack) begin
          ea_q <= mem_rdata;
          st   <= (!bop && mem_rdata[0]) ? S_ERR : S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opnd_ea_seq_chk.sv
module opnd_ea_seq_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         rf_we,
  input logic         mem_req,
  input logic [W-1:0] mem_addr,
  input logic         mem_ack,
  input logic         is_reg,
  input logic         done,
  input logic         align_err
);
  logic [1:0] wcnt, rcnt;
  always_ff @(posedge clk) begin
    if (!rst_n || done || align_err) begin
      wcnt <= '0;
      rcnt <= '0;
    end else begin
      if (rf_we) wcnt <= wcnt + 2'd1;
      if (mem_req && mem_ack) rcnt <= rcnt + 2'd1;
    end
  end

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_addr_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]);
  p_two_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack |-> rcnt < 2'd2);
  p_one_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> wcnt == 2'd0 && !done && !align_err);
  p_reg_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done && is_reg |-> wcnt == 2'd0 && rcnt == 2'd0);
  p_end_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && align_err));
  p_end_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done || align_err |=> !done && !align_err);
endmodule

bind opnd_ea_seq opnd_ea_seq_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .is_reg(is_reg),
  .done(done), .align_err(align_err)
);

// File: tb/opnd_ea_seq_tb.sv
module opnd_ea_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, byte_op = 1'b0;
  logic [5:0] spec = '0;
  logic [2:0] rf_raddr, rf_waddr;
  logic [15:0] rf_wdata, mem_addr, ea;
  logic rf_we, mem_req, is_reg, done, align_err;
  logic mem_ack = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] rf [8];
  logic [15:0] mem [256];
  logic [1:0] lat = '0;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  opnd_ea_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
    .rf_raddr(rf_raddr), .rf_rdata(rf[rf_raddr]), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .ea(ea), .is_reg(is_reg), .done(done), .align_err(align_err)
  );

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (lat == 2'd1) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[8:1]];
        lat       <= '0;
      end else lat <= lat + 2'd1;
    end else mem_ack <= 1'b0;
  end

  typedef struct {
    string rq; logic e; logic ir; logic [15:0] ea; logic [2:0] cr; logic [15:0] xr; logic [15:0] xpc;
  } item_t;
  item_t q[$];

  task automatic chk(string rq, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    item_t it;
    if (rst_n && (done || align_err)) begin
      if (q.size() == 0) chk("R10", "unexpected end", 16'd1, 16'd0);
      else begin
        it = q.pop_front();
        chk(it.rq, "align_err", {15'd0, align_err}, {15'd0, it.e});
        if (!it.e) begin
          chk(it.rq, "ea", ea, it.ea);
          chk(it.rq, "is_reg", {15'd0, is_reg}, {15'd0, it.ir});
        end
        chk(it.rq, "reg", rf[it.cr], it.xr);
        chk(it.rq, "pc", rf[7], it.xpc);
      end
    end
  end

  task automatic run(string rq, logic [2:0] m, logic [2:0] r, logic b, logic e, logic ir,
                     logic [15:0] xea, logic [2:0] cr, logic [15:0] xr, logic [15:0] xpc);
    item_t it;
    it.rq = rq; it.e = e; it.ir = ir; it.ea = xea; it.cr = cr; it.xr = xr; it.xpc = xpc;
    q.push_back(it);
    spec = {m, r}; byte_op = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!(done || align_err)) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setm(logic [15:0] a, logic [15:0] v);
    mem[a[8:1]] = v;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R10", "reset done", {15'd0, done}, 16'd0);
    chk("R10", "reset align_err", {15'd0, align_err}, 16'd0);
    chk("R10", "reset mem_req", {15'd0, mem_req}, 16'd0);
    chk("R10", "reset rf_we", {15'd0, rf_we}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rf[3] = 16'h1234; rf[7] = 16'h0000;
    run("R1", 3'd0, 3'd3, 1'b0, 1'b0, 1'b1, 16'h0003, 3'd3, 16'h1234, 16'h0000);
    rf[2] = 16'h0100;
    run("R2", 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0100, 3'd2, 16'h0100, 16'h0000);
    rf[1] = 16'h0100;
    run("R2", 3'd2, 3'd1, 1'b0, 1'b0, 1'b0, 16'h0100, 3'd1, 16'h0102, 16'h0000);
    rf[1] = 16'h0100;
    run("R2", 3'd2, 3'd1, 1'b1, 1'b0, 1'b0, 16'h0100, 3'd1, 16'h0101, 16'h0000);
    rf[3] = 16'h0104;
    run("R2", 3'd4, 3'd3, 1'b1, 1'b0, 1'b0, 16'h0103, 3'd3, 16'h0103, 16'h0000);
    rf[3] = 16'h0104;
    run("R2", 3'd4, 3'd3, 1'b0, 1'b0, 1'b0, 16'h0102, 3'd3, 16'h0102, 16'h0000);
    rf[6] = 16'h0200;
    run("R4", 3'd2, 3'd6, 1'b1, 1'b0, 1'b0, 16'h0200, 3'd6, 16'h0202, 16'h0000);
    rf[6] = 16'h0200;
    run("R4", 3'd4, 3'd6, 1'b1, 1'b0, 1'b0, 16'h01FE, 3'd6, 16'h01FE, 16'h0000);
    rf[7] = 16'h00A0;
    run("R4", 3'd4, 3'd7, 1'b1, 1'b0, 1'b0, 16'h009E, 3'd7, 16'h009E, 16'h009E);
    rf[7] = 16'h0000;
    rf[4] = 16'h0110; setm(16'h0110, 16'h0155);
    run("R3", 3'd3, 3'd4, 1'b1, 1'b0, 1'b0, 16'h0155, 3'd4, 16'h0112, 16'h0000);
    rf[5] = 16'h0120; setm(16'h011E, 16'h0180);
    run("R3", 3'd5, 3'd5, 1'b0, 1'b0, 1'b0, 16'h0180, 3'd5, 16'h011E, 16'h0000);
    rf[2] = 16'h0040; rf[7] = 16'h0010; setm(16'h0010, 16'h0020);
    run("R5", 3'd6, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0060, 3'd2, 16'h0040, 16'h0012);
    rf[7] = 16'h0014; setm(16'h0014, 16'h0100); setm(16'h0140, 16'h0088);
    run("R5", 3'd7, 3'd2, 1'b0, 1'b0, 1'b0, 16'h0088, 3'd2, 16'h0040, 16'h0016);
    rf[7] = 16'h0050; setm(16'h0050, 16'h0010);
    run("R5", 3'd6, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0062, 3'd7, 16'h0052, 16'h0052);
    rf[7] = 16'h0030; setm(16'h0030, 16'h0100); setm(16'h0132, 16'h0044);
    run("R5", 3'd7, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0044, 3'd7, 16'h0032, 16'h0032);
    rf[7] = 16'h0070;
    run("R6", 3'd2, 3'd7, 1'b0, 1'b0, 1'b0, 16'h0070, 3'd7, 16'h0072, 16'h0072);
    rf[7] = 16'h0080; setm(16'h0080, 16'h01A0);
    run("R6", 3'd3, 3'd7, 1'b0, 1'b0, 1'b0, 16'h01A0, 3'd7, 16'h0082, 16'h0082);
    rf[7] = 16'h0000;
    rf[1] = 16'h0101;
    run("R7", 3'd1, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 3'd1, 16'h0101, 16'h0000);
    run("R7", 3'd2, 3'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 3'd1, 16'h0101, 16'h0000);
    run("R7", 3'd2, 3'd1, 1'b1, 1'b0, 1'b0, 16'h0101, 3'd1, 16'h0102, 16'h0000);
    rf[2] = 16'h0105;
    run("R7", 3'd3, 3'd2, 1'b1, 1'b1, 1'b0, 16'h0000, 3'd2, 16'h0105, 16'h0000);
    rf[5] = 16'h0130; setm(16'h012E, 16'h0081);
    run("R7", 3'd5, 3'd5, 1'b0, 1'b1, 1'b0, 16'h0000, 3'd5, 16'h012E, 16'h0000);
    rf[2] = 16'h0041; rf[7] = 16'h0090; setm(16'h0090, 16'h0000);
    run("R7", 3'd6, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0000, 3'd2, 16'h0041, 16'h0092);
    rf[7] = 16'h0095;
    run("R7", 3'd6, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0000, 3'd7, 16'h0095, 16'h0095);

    chk("R9", "pending items", 16'(q.size()), 16'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule